// File: doc/BRIEF.md
# Charge-Transfer Touch Acquisition Sequencer

This block runs capacitive touch measurements. Each measurement cycle has two phases. First the electrodes are charged. Then their charge is moved into the sampling capacitors. Both phases are timed in ticks of a phase clock derived from the system clock. Six electrode groups step through these cycles together. Each group counts cycles until its comparator input reports that its sampling capacitor is full. When every enabled group has finished, the sequence ends and a completion flag is raised. If the cycle count reaches a selectable ceiling first, the sequence ends with an error flag instead.

An optional extend-charge phase can be placed between charge and transfer. It is timed by its own integer clock divider. It ends early when the electrode-charged input rises, and never runs past its programmed ceiling.

Software configures the block through a small word-addressed register interface and reads back the per-group results there. A sequence starts from a start bit written by software or, in hardware mode, from a chosen edge of a trigger input. Comparator and electrode-charged inputs are plain digital signals here.

Top module: `touch_seq`

## Requirements
- R1: The phase clock ticks once every 2^D system clocks. D is the 4-bit field CFG[3:0]. The charge phase lasts CFG[7:4]+1 ticks and the transfer phase CFG[11:8]+1 ticks. Without the extend phase, a sequence of N cycles returns to idle N*(C+T)*2^D clock edges after the edge that accepted the start.
- R2: At the last tick of each transfer phase, every enabled group that has not finished and has its comparator input high is marked finished. Its count register (address 8+g) takes the 1-based cycle number. Group done bits read at GROUP[13:8] and enables at GROUP[5:0]; a disabled group is never marked finished.
- R3: When no enabled group is left unfinished after a cycle, the sequence ends. The busy state clears by itself and the completion flag (FLAGS bit 0) is set. With no group enabled, the sequence ends after its first cycle.
- R4: CFG[14:12] = s selects a cycle ceiling of 2^(8+s)-1; codes above 6 act as 6. If a cycle reaching the ceiling still leaves a group unfinished, the sequence ends with the error flag (FLAGS bit 1) set and the completion flag left clear.
- R5: In software mode, a write of CTRL with bit 0 (enable) and bit 1 (start) both set starts a sequence from idle. While busy, a CTRL write with bit 1 clear aborts to idle within one edge and sets no flag. CTRL reads back enable at bit 0 and busy at bit 1.
- R6: In hardware mode (CFG[15]=1), software start writes are ignored. A rising trigger edge (CFG[16]=1) or falling trigger edge (CFG[16]=0) starts a sequence two clock edges after the input changes. The opposite edge starts nothing.
- R7: While busy, writes to CFG and to the sample-pin register (address 2) are ignored.
- R8: With CFG[18] set, an extend phase follows charge. It ends after M ticks of the extend clock, where M = CFG[28:22]+1 and the extend clock ticks every CFG[21:19]+1 system clocks. It ends one edge after electrode-charged is seen high, if that comes first.
- R9: padPhase shows 0 when idle, 1 in charge, 2 in extend and 3 in transfer. padIdleLow is high only when idle with CFG[17] clear.
- R10: irq is high exactly when some flag and its enable in IRQEN (address 5, same bit order as FLAGS) are both set. Writing a 1 to a bit of CLEAR (address 6) clears that flag.
- R11: After reset the block is idle and all registers read zero. padIdleLow is 1 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| trigIn | input | 1 | Hardware start trigger |
| chargedIn | input | 1 | Electrode-charged indication for the extend phase |
| cmpIn | input | 6 | Per-group sampling-capacitor comparator |
| padPhase | output | 2 | Current phase code |
| padIdleLow | output | 1 | Drive electrodes low while idle |
| samplePins | output | 24 | Sample-pin selection, four per group |
| irq | output | 1 | Interrupt request |

## Verification
A software start is taken at the edge that captures the CTRL write. A hardware start appears two edges after the trigger input changes. An abort takes effect one edge after its write. Completion and error flags, group counts and the return to idle all land together, N*(C+T)*2^D edges after the start edge, with the extend phase adding M*(E) edges. The bench drives every input on the falling clock edge and counts falling edges from the start until padPhase reads idle, then compares that count with the figure above. irq is combinational and is checked in the same half cycle as the register write that changes it.

// File: rtl/ct_touch_pkg.sv
package ct_touch_pkg;
  localparam int CNT_W = 14;
  localparam int DIV_CODES = 16;
  localparam int PRE_W = DIV_CODES - 1;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CHARGE = 2'd1,
    ST_EXTEND = 2'd2,
    ST_XFER   = 2'd3
  } seq_state_e;

  // packed MSB first; divCode lands at bit 0 of the register word
  typedef struct packed {
    logic [6:0] extMaxM1;
    logic [2:0] extDivM1;
    logic       extEn;
    logic       idleFloat;
    logic       edgeRise;
    logic       hwMode;
    logic [2:0] maxSel;
    logic [3:0] xferM1;
    logic [3:0] chargeM1;
    logic [3:0] divCode;
  } seq_cfg_t;

  typedef struct packed {
    logic seqStart;
    logic running;
    logic inExtend;
    logic evalCycle;
  } seq_strb_t;
endpackage

// File: rtl/ct_touch_regs.sv
module ct_touch_regs
  import ct_touch_pkg::*;
#(
  parameter int NUM_GROUPS = 6,
  parameter int PINS_PER_GROUP = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regWe,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [DATA_W-1:0]           regWdata,
  output logic [DATA_W-1:0]           regRdata,
  input  logic                        busy,
  input  logic                        endOk,
  input  logic                        endErr,
  input  logic [NUM_GROUPS-1:0]       grpDone,
  input  logic [NUM_GROUPS*CNT_W-1:0] grpCountFlat,
  output seq_cfg_t                    cfg,
  output logic                        blockEn,
  output logic                        swStartReq,
  output logic                        swAbortReq,
  output logic [NUM_GROUPS-1:0]       groupEn,
  output logic [NUM_GROUPS*PINS_PER_GROUP-1:0] samplePins,
  output logic                        irq
);
  localparam int PINS_W = NUM_GROUPS * PINS_PER_GROUP;
  localparam int CFG_W = $bits(seq_cfg_t);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PINS  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_GROUP = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_IRQEN = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(6);
  localparam int A_COUNT0 = 8;

  seq_cfg_t            cfgQ;
  logic                enQ;
  logic [PINS_W-1:0]   pinsQ;
  logic [NUM_GROUPS-1:0] grpEnQ;
  logic [1:0]          flagQ;
  logic [1:0]          irqEnQ;

  logic wrCtrl, wrClr;
  assign wrCtrl = regWe && (regAddr == A_CTRL);
  assign wrClr  = regWe && (regAddr == A_CLEAR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ   <= '0;
      enQ    <= 1'b0;
      pinsQ  <= '0;
      grpEnQ <= '0;
      flagQ  <= '0;
      irqEnQ <= '0;
    end else begin
      if (regWe && regAddr == A_CFG && !busy)  cfgQ  <= seq_cfg_t'(regWdata[CFG_W-1:0]);
      if (regWe && regAddr == A_PINS && !busy) pinsQ <= regWdata[PINS_W-1:0];
      if (regWe && regAddr == A_GROUP)         grpEnQ <= regWdata[NUM_GROUPS-1:0];
      if (regWe && regAddr == A_IRQEN)         irqEnQ <= regWdata[1:0];
      if (wrCtrl)                              enQ   <= regWdata[0];
      flagQ[0] <= endOk  | (flagQ[0] & ~(wrClr & regWdata[0]));
      flagQ[1] <= endErr | (flagQ[1] & ~(wrClr & regWdata[1]));
    end
  end

  assign swStartReq = wrCtrl && regWdata[1] && regWdata[0] && !cfgQ.hwMode && !busy;
  assign swAbortReq = wrCtrl && !regWdata[1] && busy;

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      A_CFG:   regRdata[CFG_W-1:0] = cfgQ;
      A_CTRL:  regRdata[1:0] = {busy, enQ};
      A_PINS:  regRdata[PINS_W-1:0] = pinsQ;
      A_GROUP: begin
        regRdata[NUM_GROUPS-1:0]   = grpEnQ;
        regRdata[8 +: NUM_GROUPS]  = grpDone;
      end
      A_FLAGS: regRdata[1:0] = flagQ;
      A_IRQEN: regRdata[1:0] = irqEnQ;
      default: begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
          if (regAddr == ADDR_W'(A_COUNT0 + g))
            regRdata[CNT_W-1:0] = grpCountFlat[g*CNT_W +: CNT_W];
        end
      end
    endcase
  end

  assign cfg        = cfgQ;
  assign blockEn    = enQ;
  assign groupEn    = grpEnQ;
  assign samplePins = pinsQ;
  assign irq        = |(flagQ & irqEnQ);

  // configuration must hold across any edge at which a sequence was running
  p_cfg_locked_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) |-> ($stable(cfgQ) && $stable(pinsQ)));
  p_ok_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    endOk |=> flagQ[0]);
  p_err_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    endErr |=> flagQ[1]);
endmodule

// File: rtl/ct_touch_ctrl.sv
module ct_touch_ctrl
  import ct_touch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] chargeM1,
  input  logic [3:0] xferM1,
  input  logic       extEn,
  input  logic [6:0] extMaxM1,
  input  logic       hwMode,
  input  logic       edgeRise,
  input  logic       blockEn,
  input  logic       swStartReq,
  input  logic       swAbortReq,
  input  logic       trigIn,
  input  logic       chargedIn,
  input  logic       phaseTick,
  input  logic       extTick,
  input  logic       allDone,
  input  logic       maxHit,
  output seq_strb_t  strb,
  output logic [1:0] phaseOut,
  output logic       busy,
  output logic       endOk,
  output logic       endErr
);
  seq_state_e stQ, stD;
  logic [3:0] phQ, phD;
  logic [6:0] exQ, exD;
  logic       trigS, trigD;
  logic       hwEdge, hwStart, startNow, evalNow;

  assign hwEdge   = edgeRise ? (trigS & ~trigD) : (~trigS & trigD);
  assign hwStart  = blockEn && hwMode && hwEdge && (stQ == ST_IDLE);
  assign startNow = swStartReq || hwStart;

  always_comb begin
    stD = stQ;
    phD = phQ;
    exD = exQ;
    endOk = 1'b0;
    endErr = 1'b0;
    evalNow = 1'b0;
    unique case (stQ)
      ST_IDLE: if (startNow) begin
        stD = ST_CHARGE;
        phD = '0;
      end
      ST_CHARGE: if (phaseTick) begin
        if (phQ == chargeM1) begin
          phD = '0;
          exD = '0;
          stD = extEn ? ST_EXTEND : ST_XFER;
        end else phD = phQ + 4'd1;
      end
      ST_EXTEND: begin
        if (chargedIn || (extTick && exQ == extMaxM1)) begin
          stD = ST_XFER;
          phD = '0;
        end else if (extTick) exD = exQ + 7'd1;
      end
      ST_XFER: if (phaseTick) begin
        if (phQ == xferM1) begin
          evalNow = 1'b1;
          phD = '0;
          if (allDone) begin
            endOk = 1'b1;
            stD = ST_IDLE;
          end else if (maxHit) begin
            endErr = 1'b1;
            stD = ST_IDLE;
          end else stD = ST_CHARGE;
        end else phD = phQ + 4'd1;
      end
      default: stD = ST_IDLE;
    endcase
    if (swAbortReq) begin
      stD = ST_IDLE;
      endOk = 1'b0;
      endErr = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ   <= ST_IDLE;
      phQ   <= '0;
      exQ   <= '0;
      trigS <= 1'b0;
      trigD <= 1'b0;
    end else begin
      stQ   <= stD;
      phQ   <= phD;
      exQ   <= exD;
      trigS <= trigIn;
      trigD <= trigS;
    end
  end

  assign strb.seqStart  = (stQ == ST_IDLE) && startNow;
  assign strb.running   = (stQ != ST_IDLE);
  assign strb.inExtend  = (stQ == ST_EXTEND);
  assign strb.evalCycle = evalNow;
  assign phaseOut = stQ;
  assign busy     = (stQ != ST_IDLE);

  p_charge_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_CHARGE) |-> (phQ <= chargeM1));
  p_ext_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_EXTEND) |-> (exQ <= extMaxM1));
  p_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.seqStart |=> (stQ == ST_CHARGE));
  p_end_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (endOk || endErr) |=> (stQ == ST_IDLE));
endmodule

// File: rtl/ct_touch_dp.sv
module ct_touch_dp
  import ct_touch_pkg::*;
#(
  parameter int NUM_GROUPS = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [3:0]                  divCode,
  input  logic [2:0]                  extDivM1,
  input  logic [2:0]                  maxSel,
  input  seq_strb_t                   strb,
  input  logic [NUM_GROUPS-1:0]       cmpIn,
  input  logic [NUM_GROUPS-1:0]       groupEn,
  output logic                        phaseTick,
  output logic                        extTick,
  output logic                        allDone,
  output logic                        maxHit,
  output logic [NUM_GROUPS-1:0]       grpDone,
  output logic [NUM_GROUPS*CNT_W-1:0] grpCountFlat
);
  localparam int MAX_SEL_TOP = 6;

  logic [PRE_W-1:0]      preQ, preMask;
  logic [2:0]            extPreQ;
  logic [CNT_W-1:0]      cycQ, cycNext, maxLim;
  logic [2:0]            selC;
  logic [NUM_GROUPS-1:0] newDone;

  assign preMask   = PRE_W'((32'd1 << divCode) - 32'd1);
  assign phaseTick = strb.running && ((preQ & preMask) == preMask);
  assign extTick   = strb.inExtend && (extPreQ == extDivM1);
  assign selC      = (maxSel > 3'(MAX_SEL_TOP)) ? 3'(MAX_SEL_TOP) : maxSel;
  assign maxLim    = CNT_W'((32'd256 << selC) - 32'd1);
  assign cycNext   = cycQ + CNT_W'(1);
  assign maxHit    = (cycNext == maxLim);
  assign newDone   = groupEn & cmpIn & ~grpDone;
  assign allDone   = ((groupEn & ~grpDone & ~cmpIn) == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preQ    <= '0;
      extPreQ <= '0;
      cycQ    <= '0;
    end else begin
      preQ    <= strb.running ? preQ + PRE_W'(1) : '0;
      extPreQ <= (!strb.inExtend || extTick) ? 3'd0 : extPreQ + 3'd1;
      if (strb.seqStart)       cycQ <= '0;
      else if (strb.evalCycle) cycQ <= cycNext;
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic [CNT_W-1:0] cntQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ       <= '0;
        grpDone[g] <= 1'b0;
      end else if (strb.seqStart) begin
        cntQ       <= '0;
        grpDone[g] <= 1'b0;
      end else if (strb.evalCycle && newDone[g]) begin
        cntQ       <= cycNext;
        grpDone[g] <= 1'b1;
      end
    end
    assign grpCountFlat[g*CNT_W +: CNT_W] = cntQ;
  end

  // finished groups stay finished until the next sequence start
  p_done_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.seqStart) |-> (($past(grpDone) & ~grpDone) == '0));
  p_cyc_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.running |-> (cycQ < maxLim));
endmodule

// File: rtl/touch_seq.sv
module touch_seq
  import ct_touch_pkg::*;
#(
  parameter int NUM_GROUPS = 6,
  parameter int PINS_PER_GROUP = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWe,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [DATA_W-1:0]      regWdata,
  output logic [DATA_W-1:0]      regRdata,
  input  logic                   trigIn,
  input  logic                   chargedIn,
  input  logic [NUM_GROUPS-1:0]  cmpIn,
  output logic [1:0]             padPhase,
  output logic                   padIdleLow,
  output logic [NUM_GROUPS*PINS_PER_GROUP-1:0] samplePins,
  output logic                   irq
);
  seq_cfg_t  cfg;
  seq_strb_t strb;
  logic blockEn, swStartReq, swAbortReq, busy, endOk, endErr;
  logic phaseTick, extTick, allDone, maxHit;
  logic [NUM_GROUPS-1:0]       groupEn, grpDone;
  logic [NUM_GROUPS*CNT_W-1:0] grpCountFlat;

  ct_touch_regs #(
    .NUM_GROUPS(NUM_GROUPS), .PINS_PER_GROUP(PINS_PER_GROUP),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busy(busy),
    .endOk(endOk), .endErr(endErr), .grpDone(grpDone),
    .grpCountFlat(grpCountFlat), .cfg(cfg), .blockEn(blockEn),
    .swStartReq(swStartReq), .swAbortReq(swAbortReq),
    .groupEn(groupEn), .samplePins(samplePins), .irq(irq)
  );

  ct_touch_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .chargeM1(cfg.chargeM1), .xferM1(cfg.xferM1),
    .extEn(cfg.extEn), .extMaxM1(cfg.extMaxM1), .hwMode(cfg.hwMode),
    .edgeRise(cfg.edgeRise), .blockEn(blockEn), .swStartReq(swStartReq),
    .swAbortReq(swAbortReq), .trigIn(trigIn), .chargedIn(chargedIn),
    .phaseTick(phaseTick), .extTick(extTick), .allDone(allDone),
    .maxHit(maxHit), .strb(strb), .phaseOut(padPhase), .busy(busy),
    .endOk(endOk), .endErr(endErr)
  );

  ct_touch_dp #(.NUM_GROUPS(NUM_GROUPS)) u_dp (
    .clk(clk), .rstN(rstN), .divCode(cfg.divCode), .extDivM1(cfg.extDivM1),
    .maxSel(cfg.maxSel), .strb(strb), .cmpIn(cmpIn), .groupEn(groupEn),
    .phaseTick(phaseTick), .extTick(extTick), .allDone(allDone),
    .maxHit(maxHit), .grpDone(grpDone), .grpCountFlat(grpCountFlat)
  );

  assign padIdleLow = !busy && !cfg.idleFloat;
endmodule

// File: tb/tb_touch_seq.sv
`timescale 1ns/1ps
module tb_touch_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        trigIn = 1'b0;
  logic        chargedIn = 1'b0;
  logic [5:0]  cmpIn = '0;
  logic [1:0]  padPhase;
  logic        padIdleLow;
  logic [23:0] samplePins;
  logic        irq;
  int nChk = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  touch_seq dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .trigIn(trigIn),
    .chargedIn(chargedIn), .cmpIn(cmpIn), .padPhase(padPhase),
    .padIdleLow(padIdleLow), .samplePins(samplePins), .irq(irq)
  );

  typedef struct packed {
    logic [3:0]  div;
    logic [3:0]  cm1;
    logic [3:0]  xm1;
    logic [5:0]  en;
    logic [5:0]  cmp;
    logic [15:0] edges;
    logic [13:0] cnt0;
    logic [5:0]  done;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'd0, 4'd0,  4'd0,  6'h01, 6'h3F, 16'd2,  14'd1, 6'h01},
    '{4'd0, 4'd3,  4'd2,  6'h01, 6'h01, 16'd7,  14'd1, 6'h01},
    '{4'd2, 4'd1,  4'd0,  6'h01, 6'h01, 16'd12, 14'd1, 6'h01},
    '{4'd1, 4'd15, 4'd15, 6'h01, 6'h01, 16'd64, 14'd1, 6'h01},
    '{4'd0, 4'd2,  4'd1,  6'h3F, 6'h3F, 16'd5,  14'd1, 6'h3F},
    '{4'd0, 4'd1,  4'd1,  6'h00, 6'h00, 16'd4,  14'd0, 6'h00}
  };

  function automatic logic [31:0] mkCfg(logic [3:0] div, logic [3:0] cm1, logic [3:0] xm1,
                                        logic [2:0] maxSel, logic hw, logic rise, logic flt,
                                        logic ext, logic [2:0] extDivM1, logic [6:0] extMaxM1);
    return {3'b000, extMaxM1, extDivM1, ext, flt, rise, hw, maxSel, xm1, cm1, div};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  // called at the falling edge after the start edge; returns edges until idle
  task automatic runWait(output int n);
    n = 0;
    while (padPhase != 2'd0 && n < 40000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish();
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 padPhase", 32'(padPhase), 0);
    chk("R11 padIdleLow", 32'(padIdleLow), 1);
    chk("R11 irq", 32'(irq), 0);
    rd(4'd4, d); chk("R11 flags", d, 0);
    rd(4'd1, d); chk("R11 ctrl", d, 0);
    rd(4'd0, d); chk("R11 cfg", d, 0);

    // R1 R2 R3 vector table
    for (int i = 0; i < 6; i++) begin
      wr(4'd0, mkCfg(VECS[i].div, VECS[i].cm1, VECS[i].xm1, 3'd6, 0, 0, 0, 0, 3'd0, 7'd0));
      wr(4'd3, 32'(VECS[i].en));
      cmpIn = VECS[i].cmp;
      wr(4'd6, 32'd3);
      wr(4'd1, 32'd3);
      runWait(n);
      chk("R1 sequence length", 32'(n), 32'(VECS[i].edges));
      rd(4'd4, d); chk("R3 complete flag", d, 1);
      rd(4'd8, d); chk("R2 group0 count", d, 32'(VECS[i].cnt0));
      rd(4'd3, d); chk("R2 done mask", 32'(d[13:8]), 32'(VECS[i].done));
      rd(4'd1, d); chk("R3 busy cleared", d, 1);
    end

    // R2 per-group counts differ: group1 trips on cycle 5
    wr(4'd0, mkCfg(4'd0, 4'd0, 4'd0, 3'd6, 0, 0, 0, 0, 3'd0, 7'd0));
    wr(4'd3, 32'h03);
    cmpIn = 6'h01;
    wr(4'd1, 32'd3);
    repeat (9) @(negedge clk);
    cmpIn = 6'h03;
    runWait(n);
    chk("R2 staggered length", 32'(n + 9), 10);
    rd(4'd8, d); chk("R2 group0 count", d, 1);
    rd(4'd9, d); chk("R2 group1 count", d, 5);

    // R10 interrupt gating and clear
    wr(4'd5, 32'd0);
    chk("R10 irq masked", 32'(irq), 0);
    wr(4'd5, 32'd2);
    chk("R10 irq other enable", 32'(irq), 0);
    wr(4'd5, 32'd1);
    chk("R10 irq raised", 32'(irq), 1);
    wr(4'd6, 32'd1);
    chk("R10 irq after clear", 32'(irq), 0);
    rd(4'd4, d); chk("R10 flag cleared", d, 0);

    // R4 ceiling 255 and 511
    cmpIn = 6'h00;
    wr(4'd3, 32'h01);
    wr(4'd5, 32'd2);
    wr(4'd0, mkCfg(4'd0, 4'd0, 4'd0, 3'd0, 0, 0, 0, 0, 3'd0, 7'd0));
    wr(4'd1, 32'd3);
    runWait(n);
    chk("R4 length 255 cycles", 32'(n), 510);
    rd(4'd4, d); chk("R4 error flag only", d, 2);
    chk("R4 irq on error", 32'(irq), 1);
    rd(4'd3, d); chk("R4 no group done", 32'(d[13:8]), 0);
    wr(4'd6, 32'd3);
    wr(4'd0, mkCfg(4'd0, 4'd0, 4'd0, 3'd1, 0, 0, 0, 0, 3'd0, 7'd0));
    wr(4'd1, 32'd3);
    runWait(n);
    chk("R4 length 511 cycles", 32'(n), 1022);
    wr(4'd6, 32'd3);
    wr(4'd5, 32'd0);

    // R8 extend phase: full length and early end
    cmpIn = 6'h01;
    wr(4'd0, mkCfg(4'd0, 4'd0, 4'd0, 3'd6, 0, 0, 0, 1, 3'd2, 7'd3));
    wr(4'd1, 32'd3);
    @(negedge clk);
    chk("R9 extend phase code", 32'(padPhase), 2);
    runWait(n);
    chk("R8 extend full length", 32'(n + 1), 14);
    chargedIn = 1'b1;
    wr(4'd1, 32'd3);
    runWait(n);
    chk("R8 extend early end", 32'(n), 3);
    chargedIn = 1'b0;

    // R7 config lock and R5 abort
    wr(4'd6, 32'd3);
    wr(4'd2, 32'h00ABCDEF);
    chk("R7 pins idle write", 32'(samplePins), 32'h00ABCDEF);
    wr(4'd0, mkCfg(4'd3, 4'd15, 4'd15, 3'd6, 0, 0, 0, 0, 3'd0, 7'd0));
    wr(4'd1, 32'd3);
    chk("R9 charge phase code", 32'(padPhase), 1);
    wr(4'd0, 32'd0);
    wr(4'd2, 32'h00123456);
    rd(4'd0, d); chk("R7 cfg locked", d, mkCfg(4'd3, 4'd15, 4'd15, 3'd6, 0, 0, 0, 0, 3'd0, 7'd0));
    chk("R7 pins locked", 32'(samplePins), 32'h00ABCDEF);
    chk("R9 no idle drive while busy", 32'(padIdleLow), 0);
    wr(4'd1, 32'd1);
    chk("R5 abort to idle", 32'(padPhase), 0);
    rd(4'd4, d); chk("R5 abort sets no flag", d, 0);

    // R9 idle float
    wr(4'd0, mkCfg(4'd0, 4'd0, 4'd0, 3'd6, 0, 0, 1, 0, 3'd0, 7'd0));
    chk("R9 idle float", 32'(padIdleLow), 0);

    // R6 hardware trigger
    wr(4'd0, mkCfg(4'd0, 4'd0, 4'd0, 3'd6, 1, 1, 0, 0, 3'd0, 7'd0));
    wr(4'd1, 32'd3);
    chk("R6 software start ignored", 32'(padPhase), 0);
    wr(4'd1, 32'd1);
    trigIn = 1'b1;
    @(negedge clk);
    chk("R6 not yet started", 32'(padPhase), 0);
    @(negedge clk);
    chk("R6 rising start", 32'(padPhase), 1);
    runWait(n);
    trigIn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 falling ignored in rising mode", 32'(padPhase), 0);
    wr(4'd0, mkCfg(4'd0, 4'd0, 4'd0, 3'd6, 1, 0, 0, 0, 3'd0, 7'd0));
    trigIn = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 rising ignored in falling mode", 32'(padPhase), 0);
    trigIn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R6 falling start", 32'(padPhase), 1);
    runWait(n);
    rd(4'd4, d); chk("R6 hardware run completes", d, 1);

    finish();
  end
endmodule